// File: doc/BRIEF.md
# Snooping Invalidation Controller with Exclusive-Clean Lines

This block keeps one private write-back cache coherent with its peers on a shared bus. It tracks a state and a tag for each line of a direct-mapped cache and serves processor reads and writes. A line is invalid, exclusive-clean, shared-clean or dirty. On a miss it issues a block read or a read-for-write, and it issues an invalidate when a write hits a shared line. A dirty victim is written back before its slot is refilled. An external arbiter grants the bus, and the controller then holds the bus for a fixed number of cycles that depends on the command.

A wired-OR "supplied by a cache" line is sampled in the grant cycle. It tells the controller whether another cache supplied the missed block. A block nobody else holds is loaded exclusive-clean, and the first write to it is silent.

On the snoop side the controller answers every bus command for a block it holds. It raises the hold response. It drives the data when no cache of higher index priority also holds the block, and it flags a memory update when it supplies a dirty block on a plain read. It then downgrades or invalidates its own copy.

Top module: `coh_ctrl`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high, and `bus_req` and `bus_busy` are low. A snoop of any address gets no hold response.
- R2: A read miss with `bus_shared_in` low in the grant cycle loads the line exclusive-clean. A later write to it completes one cycle after acceptance with no bus request.
- R3: A read miss with `bus_shared_in` high loads the line shared. A later write to it issues an invalidate (`bus_cmd`=2), and once done the line is dirty.
- R4: A write miss issues a read-for-write (`bus_cmd`=1) and loads the line dirty.
- R5: A read hit in any valid state, and a write hit on a dirty line, each complete one cycle after acceptance with no bus request.
- R6: A snooped block read (`snp_cmd`=0) of a held line raises `snp_hold` and leaves the line shared. `snp_supply` is also raised unless `snp_prio_block` is high.
- R7: When the controller supplies a dirty line for a snooped block read, `snp_flush` is raised in the same cycle. `snp_flush` stays low for clean lines and for read-for-write.
- R8: A snooped read-for-write (1) or invalidate (2) of a held line raises `snp_hold` and invalidates the line. A read-for-write also raises `snp_supply`, and an invalidate never does.
- R9: A miss whose slot holds a dirty line of another tag first issues a write-back (`bus_cmd`=3) at the victim's address, then the fill. A clean victim is dropped with no write-back.
- R10: An invalidate holds the bus for one cycle and every other command for BLOCK_CYC cycles (`bus_busy` high). `req_done` rises in the cycle after the last bus cycle.
- R11: If a pending invalidate's line is invalidated by a snoop before the grant, the controller issues a read-for-write instead.
- R12: In a cycle with `snp_valid` high no processor request is accepted. A snooped write-back (3) gets no response and leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Block address of the request |
| req_ready | output | 1 | Request accepted at this edge |
| req_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus wanted for the command on `bus_cmd` |
| bus_cmd | output | 2 | 0 read, 1 read-for-write, 2 invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Block address of the bus command |
| bus_gnt | input | 1 | Grant; this cycle is the snoop response cycle |
| bus_shared_in | input | 1 | Wired-OR: another cache supplies the block |
| bus_busy | output | 1 | Controller owns the bus this cycle |
| snp_valid | input | 1 | Another master's command is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_prio_block | input | 1 | A higher-priority cache also holds the block |
| snp_hold | output | 1 | This cache holds the block (drives the shared line) |
| snp_supply | output | 1 | This cache drives the block data |
| snp_flush | output | 1 | Supplied data is dirty and also updates memory |

## Verification
A hit completes one cycle after the accepting edge. A miss, with a grant given as soon as `bus_req` appears, completes after one cycle plus the sum of the bus costs of its commands: 5 cycles for a fill, 2 for an invalidate, and 9 for a write-back followed by a fill. The bench drives and samples on the falling edge and counts the cycles from acceptance to `req_done`. It counts `bus_busy` cycles shortly after each falling edge and compares each total against the sum of costs. Snoop responses are combinational and are sampled one time unit after the snoop inputs change. Each granted command is popped from an expected queue and compared in its grant cycle.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LN_INV   = 2'd0,
        LN_EXCL  = 2'd1,
        LN_SHRD  = 2'd2,
        LN_DIRTY = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_RD  = 2'd0,
        BC_RDX = 2'd1,
        BC_INV = 2'd2,
        BC_WB  = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_WAIT = 2'd1,
        M_XFER = 2'd2
    } mst_e;

    function automatic logic line_valid(line_st_e s);
        return s != LN_INV;
    endfunction

    function automatic logic may_write(line_st_e s);
        return (s == LN_EXCL) || (s == LN_DIRTY);
    endfunction

    // state a line takes when the named command completes for this cache
    function automatic line_st_e fill_state(bus_cmd_e c, logic shared);
        case (c)
            BC_RD:   return shared ? LN_SHRD : LN_EXCL;
            BC_RDX:  return LN_DIRTY;
            BC_INV:  return LN_DIRTY;
            default: return LN_INV;
        endcase
    endfunction

endpackage

// File: rtl/coh_tags.sv
module coh_tags
    import coh_pkg::*;
#(
    parameter int LINES = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] p_idx,
    output line_st_e         p_st,
    output logic [TAG_W-1:0] p_tag,
    input  logic [IDX_W-1:0] s_idx,
    output line_st_e         s_st,
    output logic [TAG_W-1:0] s_tag,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  line_st_e         w_st,
    input  logic [TAG_W-1:0] w_tag
);

    line_st_e         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    assign p_st  = st_q[p_idx];
    assign p_tag = tag_q[p_idx];
    assign s_st  = st_q[s_idx];
    assign s_tag = tag_q[s_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]  <= LN_INV;
                tag_q[i] <= '0;
            end
        end else if (we) begin
            st_q[w_idx]  <= w_st;
            tag_q[w_idx] <= w_tag;
        end
    end

endmodule

// File: rtl/coh_snoop.sv
module coh_snoop
    import coh_pkg::*;
#(
    parameter int TAG_W = 9
) (
    input  logic             snp_valid,
    input  bus_cmd_e         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_e         s_st,
    input  logic [TAG_W-1:0] s_tag,
    input  logic             prio_block,
    output logic             hold,
    output logic             supply,
    output logic             flush,
    output logic             upd,
    output line_st_e         upd_st
);

    logic match;
    logic act;

    assign match  = line_valid(s_st) && (s_tag == snp_tag);
    // write-backs from peers never concern a block this cache still holds
    assign act    = snp_valid && match && (snp_cmd != BC_WB);
    assign hold   = act;
    assign supply = act && (snp_cmd != BC_INV) && !prio_block;
    assign flush  = act && (snp_cmd == BC_RD) && (s_st == LN_DIRTY) && !prio_block;
    assign upd    = act;
    assign upd_st = (snp_cmd == BC_RD) ? LN_SHRD : LN_INV;

endmodule

// File: rtl/coh_master.sv
module coh_master
    import coh_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int IDX_W     = 3,
    parameter int TAG_W     = 9,
    parameter int BLOCK_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              snp_valid,
    input  line_st_e          p_st,
    input  logic [TAG_W-1:0]  p_tag,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    output logic              req_ready,
    output logic              req_done,
    output logic              bus_req,
    output bus_cmd_e          bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_busy,
    output logic [IDX_W-1:0]  p_idx,
    output logic              upd,
    output logic [IDX_W-1:0]  upd_idx,
    output line_st_e          upd_st,
    output logic [TAG_W-1:0]  upd_tag
);

    localparam int CNT_W = $clog2(BLOCK_CYC + 1);

    mst_e              st_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    bus_cmd_e          cmd_q;
    logic              sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;

    logic [ADDR_W-1:0] addr_sel;
    logic [TAG_W-1:0]  tag_sel;
    logic              hit, accept, local_ok;
    bus_cmd_e          need;
    logic              fin_wait, fin_xfer;
    bus_cmd_e          fin_cmd;

    assign addr_sel = (st_q == M_IDLE) ? req_addr : addr_q;
    assign tag_sel  = addr_sel[ADDR_W-1:IDX_W];
    assign p_idx    = addr_sel[IDX_W-1:0];
    assign hit      = line_valid(p_st) && (p_tag == tag_sel);
    assign accept   = (st_q == M_IDLE) && req_valid && !snp_valid;
    assign local_ok = hit && (!req_write || may_write(p_st));

    // re-evaluated every waiting cycle, so snoops that land first are honoured
    always_comb begin
        if (hit && p_st == LN_SHRD)
            need = BC_INV;
        else if (!hit && p_st == LN_DIRTY)
            need = BC_WB;
        else if (wr_q)
            need = BC_RDX;
        else
            need = BC_RD;
    end

    assign fin_wait = (st_q == M_WAIT) && bus_gnt && (need == BC_INV);
    assign fin_xfer = (st_q == M_XFER) && (cnt_q == CNT_W'(1));
    assign fin_cmd  = fin_wait ? need : cmd_q;

    always_comb begin
        upd     = 1'b0;
        upd_st  = LN_INV;
        upd_tag = tag_sel;
        upd_idx = p_idx;
        if (accept && local_ok && req_write) begin
            upd    = 1'b1;
            upd_st = LN_DIRTY;
        end else if (fin_wait || fin_xfer) begin
            upd    = 1'b1;
            upd_st = fill_state(fin_cmd, sh_q);
        end
    end

    assign req_ready = (st_q == M_IDLE) && !snp_valid;
    assign req_done  = done_q;
    assign bus_req   = (st_q == M_WAIT);
    assign bus_cmd   = need;
    assign bus_addr  = (need == BC_WB) ? {p_tag, p_idx} : addr_q;
    assign bus_busy  = ((st_q == M_WAIT) && bus_gnt) || (st_q == M_XFER);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= M_IDLE;
            wr_q   <= 1'b0;
            addr_q <= '0;
            cmd_q  <= BC_RD;
            sh_q   <= 1'b0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                M_IDLE: begin
                    if (accept) begin
                        wr_q   <= req_write;
                        addr_q <= req_addr;
                        if (local_ok) done_q <= 1'b1;
                        else          st_q   <= M_WAIT;
                    end
                end
                M_WAIT: begin
                    if (bus_gnt) begin
                        cmd_q <= need;
                        sh_q  <= bus_shared_in;
                        if (need == BC_INV) begin
                            st_q   <= M_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            st_q  <= M_XFER;
                            cnt_q <= CNT_W'(BLOCK_CYC - 1);
                        end
                    end
                end
                M_XFER: begin
                    if (cnt_q == CNT_W'(1)) begin
                        st_q   <= (cmd_q == BC_WB) ? M_WAIT : M_IDLE;
                        done_q <= (cmd_q != BC_WB);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= M_IDLE;
            endcase
        end
    end

    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (st_q == M_XFER) |-> !bus_req); // R10
    AST_INV_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt && bus_req && bus_cmd == BC_INV) |=> !bus_busy); // R10
    AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_gnt && bus_req && bus_cmd != BC_INV) |=> bus_busy); // R10
    AST_DONE_OFF_BUS: assert property (@(posedge clk) disable iff (rst)
        req_done |-> !bus_busy); // R10

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int LINES     = 8,
    parameter int BLOCK_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              req_done,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    output logic              bus_busy,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_prio_block,
    output logic              snp_hold,
    output logic              snp_supply,
    output logic              snp_flush
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_st_e         p_st, s_st, m_upd_st, s_upd_st, w_st;
    logic [TAG_W-1:0] p_tag, s_tag, m_upd_tag, w_tag;
    logic [IDX_W-1:0] p_idx, m_upd_idx, w_idx;
    logic             m_upd, s_upd;
    bus_cmd_e         m_cmd;

    // snoop updates and local completions never share a cycle; snoop first anyway
    assign w_idx = s_upd ? snp_addr[IDX_W-1:0] : m_upd_idx;
    assign w_st  = s_upd ? s_upd_st : m_upd_st;
    assign w_tag = s_upd ? snp_addr[ADDR_W-1:IDX_W] : m_upd_tag;
    assign bus_cmd = m_cmd;

    coh_tags #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk   (clk),
        .rst   (rst),
        .p_idx (p_idx),
        .p_st  (p_st),
        .p_tag (p_tag),
        .s_idx (snp_addr[IDX_W-1:0]),
        .s_st  (s_st),
        .s_tag (s_tag),
        .we    (s_upd || m_upd),
        .w_idx (w_idx),
        .w_st  (w_st),
        .w_tag (w_tag)
    );

    coh_snoop #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid  (snp_valid),
        .snp_cmd    (bus_cmd_e'(snp_cmd)),
        .snp_tag    (snp_addr[ADDR_W-1:IDX_W]),
        .s_st       (s_st),
        .s_tag      (s_tag),
        .prio_block (snp_prio_block),
        .hold       (snp_hold),
        .supply     (snp_supply),
        .flush      (snp_flush),
        .upd        (s_upd),
        .upd_st     (s_upd_st)
    );

    coh_master #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
                 .BLOCK_CYC(BLOCK_CYC)) u_master (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .snp_valid     (snp_valid),
        .p_st          (p_st),
        .p_tag         (p_tag),
        .bus_gnt       (bus_gnt),
        .bus_shared_in (bus_shared_in),
        .req_ready     (req_ready),
        .req_done      (req_done),
        .bus_req       (bus_req),
        .bus_cmd       (m_cmd),
        .bus_addr      (bus_addr),
        .bus_busy      (bus_busy),
        .p_idx         (p_idx),
        .upd           (m_upd),
        .upd_idx       (m_upd_idx),
        .upd_st        (m_upd_st),
        .upd_tag       (m_upd_tag)
    );

    AST_SNOOP_BLOCKS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && req_valid && !bus_req && !bus_busy) |=> (!req_done && !bus_req)); // R12
    AST_INVAL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_hold && (snp_cmd == 2'd1 || snp_cmd == 2'd2))
        ##1 (snp_valid && snp_addr == $past(snp_addr)) |-> !snp_hold); // R8

endmodule

// File: tb/coh_ctrl_test.sv
module coh_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 12;
    localparam int LINES = 8;
    localparam int BLOCK_CYC = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_ready, req_done, bus_req, bus_busy;
    logic [1:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_gnt = 1'b0;
    logic              bus_shared_in;
    logic              snp_valid = 1'b0, snp_prio_block = 1'b0;
    logic [1:0]        snp_cmd = 2'd0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_hold, snp_supply, snp_flush;

    int total = 0;
    int bad = 0;
    int busy_cnt = 0;
    bit hold_grant = 1'b0;
    bit shared_resp = 1'b0;

    typedef struct {
        logic [1:0]        cmd;
        logic [ADDR_W-1:0] addr;
        string             rq;
    } exp_t;
    exp_t expq[$];

    assign bus_shared_in = shared_resp;

    coh_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES), .BLOCK_CYC(BLOCK_CYC)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_ready(req_ready), .req_done(req_done),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in), .bus_busy(bus_busy),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_prio_block(snp_prio_block),
        .snp_hold(snp_hold), .snp_supply(snp_supply), .snp_flush(snp_flush)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic expect_bus(input logic [1:0] c, input logic [ADDR_W-1:0] a,
                              input string rq);
        exp_t e;
        e.cmd = c; e.addr = a; e.rq = rq;
        expq.push_back(e);
    endtask

    // bus responder and scoreboard monitor: grants immediately unless held
    always @(negedge clk) begin
        if (bus_req && !hold_grant && !rst) begin
            bus_gnt = 1'b1;
            if (expq.size() == 0) begin
                chk(1'b0, "R10", "unexpected bus command", int'(bus_cmd), 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(bus_cmd == e.cmd, e.rq, "bus_cmd", int'(bus_cmd), int'(e.cmd));
                chk(bus_addr == e.addr, e.rq, "bus_addr", int'(bus_addr), int'(e.addr));
            end
        end else begin
            bus_gnt = 1'b0;
        end
    end

    always @(negedge clk) begin
        #1;
        if (bus_busy) busy_cnt++;
    end

    task automatic proc_op(input bit wr, input logic [ADDR_W-1:0] a,
                           input int exp_lat, input int exp_busy, input string rq);
        int lat;
        int b0;
        int guard;
        @(negedge clk);
        guard = 0;
        while (!req_ready && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        b0 = busy_cnt;
        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!req_done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        if (exp_lat >= 0) chk(lat == exp_lat, rq, "latency", lat, exp_lat);
        else chk(req_done, rq, "completion", int'(req_done), 1);
        if (exp_busy >= 0)
            chk(busy_cnt - b0 == exp_busy, rq, "busy cycles", busy_cnt - b0, exp_busy);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [ADDR_W-1:0] a, input bit blk,
                         input bit eh, input bit es, input bit ef, input string rq);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_prio_block = blk;
        #1;
        chk(snp_hold == eh, rq, "snp_hold", int'(snp_hold), int'(eh));
        chk(snp_supply == es, rq, "snp_supply", int'(snp_supply), int'(es));
        chk(snp_flush == ef, rq, "snp_flush", int'(snp_flush), int'(ef));
        @(negedge clk);
        snp_valid = 1'b0; snp_prio_block = 1'b0;
    endtask

    localparam logic [ADDR_W-1:0] A = 12'h010, B = 12'h021, C = 12'h032,
                                  D = 12'h043, E = 12'h050, F = 12'h062,
                                  G = 12'h074, H = 12'h0F5;

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
        chk(bus_req == 1'b0, "R1", "bus_req", int'(bus_req), 0);
        chk(bus_busy == 1'b0, "R1", "bus_busy", int'(bus_busy), 0);
        snoop(2'd0, A, 1'b0, 1'b0, 1'b0, 1'b0, "R1");

        // R2 exclusive fill, then silent write
        shared_resp = 1'b0;
        expect_bus(2'd0, A, "R2");
        proc_op(1'b0, A, 5, BLOCK_CYC, "R2");
        proc_op(1'b1, A, 1, 0, "R2");

        // R6 R7 supply of a dirty line, then R3 upgrade
        snoop(2'd0, A, 1'b0, 1'b1, 1'b1, 1'b1, "R7");
        expect_bus(2'd2, A, "R3");
        proc_op(1'b1, A, 2, 1, "R3");

        shared_resp = 1'b1;
        expect_bus(2'd0, B, "R3");
        proc_op(1'b0, B, 5, BLOCK_CYC, "R3");
        expect_bus(2'd2, B, "R3");
        proc_op(1'b1, B, 2, 1, "R3");
        proc_op(1'b1, B, 1, 0, "R3");

        // R6 priority among shared holders
        expect_bus(2'd0, C, "R6");
        proc_op(1'b0, C, 5, BLOCK_CYC, "R6");
        snoop(2'd0, C, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        snoop(2'd0, C, 1'b0, 1'b1, 1'b1, 1'b0, "R6");

        // R4 write miss, R5 hits on dirty
        expect_bus(2'd1, D, "R4");
        proc_op(1'b1, D, 5, BLOCK_CYC, "R4");
        proc_op(1'b0, D, 1, 0, "R5");
        proc_op(1'b1, D, 1, 0, "R5");

        // R12 snooped write-back ignored, snoop blocks acceptance
        snoop(2'd3, D, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
        proc_op(1'b1, D, 1, 0, "R12");
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'd0; snp_addr = H;
        req_valid = 1'b1; req_write = 1'b0; req_addr = D;
        #1;
        chk(req_ready == 1'b0, "R12", "req_ready in snoop cycle", int'(req_ready), 0);
        chk(snp_hold == 1'b0, "R12", "snp_hold unheld", int'(snp_hold), 0);
        @(negedge clk);
        chk(req_done == 1'b0, "R12", "no done after snoop cycle", int'(req_done), 0);
        snp_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_done == 1'b1, "R12", "done after late accept", int'(req_done), 1);

        // R8 read-for-write snoop takes and invalidates the line
        snoop(2'd1, D, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
        shared_resp = 1'b0;
        expect_bus(2'd0, D, "R8");
        proc_op(1'b0, D, 5, BLOCK_CYC, "R8");

        // R9 dirty victim written back, clean victim dropped
        expect_bus(2'd3, A, "R9");
        expect_bus(2'd0, E, "R9");
        proc_op(1'b0, E, 9, 2 * BLOCK_CYC, "R9");
        expect_bus(2'd0, F, "R9");
        proc_op(1'b0, F, 5, BLOCK_CYC, "R9");

        // R8 invalidate snoop: no data
        snoop(2'd2, E, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        expect_bus(2'd0, E, "R8");
        proc_op(1'b0, E, 5, BLOCK_CYC, "R8");

        // R11 upgrade lost to a peer's invalidate before grant
        shared_resp = 1'b1;
        expect_bus(2'd0, G, "R11");
        proc_op(1'b0, G, 5, BLOCK_CYC, "R11");
        hold_grant = 1'b1;
        expect_bus(2'd1, G, "R11");
        fork
            proc_op(1'b1, G, -1, -1, "R11");
            begin
                int g = 0;
                @(negedge clk);
                while (!bus_req && g < 50) begin
                    @(negedge clk);
                    g++;
                end
                snoop(2'd2, G, 1'b0, 1'b1, 1'b0, 1'b0, "R11");
                hold_grant = 1'b0;
            end
        join
        proc_op(1'b1, G, 1, 0, "R11");

        repeat (2) @(negedge clk);
        chk(expq.size() == 0, "R10", "pending expected bus commands", expq.size(), 0);
        finish_run();
    end

endmodule